// File: doc/BRIEF.md
# Strip Cluster Finder

This block takes a snapshot of a detector's strip hit pattern, one bit per strip, and reduces it to a list of clusters. A cluster is a run of adjacent hit strips. The strip vector is cut into fixed regions of twelve strips. Every region has its own extraction engine, and all engines work at the same time. An engine first marks where its runs begin and where they end. It then removes the topmost remaining run once per clock, using a priority encoder on each mark vector. This takes a fixed number of clocks, whatever the hit pattern.

The records found are held per region. A merger then sends them out as a single stream, one record per clock. Each record carries the cluster centre as an absolute strip number and the cluster width. A done pulse closes the stream. A new snapshot is taken only when the block is idle.

Top module: `strip_cluster_finder`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `clu_valid_o` and `done_o` are low.
- R2: Bit i of `hits_i` is strip i. Strips are grouped into regions of 12, so region r holds strips 12r to 12r+11. A cluster is a maximal run of set bits inside one region.
- R3: A run that crosses a region boundary is reported as two separate clusters, one for each region it touches. Strips outside a region count as empty for that region.
- R4: `clu_center_o` equals 12r + floor((lo+hi)/2). Here lo and hi are the region-local indices (0 to 11) of the lowest and highest strip of the run.
- R5: `clu_width_o` equals hi-lo+1, and saturates at 7. It is never 0 on a valid record.
- R6: Every cluster of every region is reported. This needs no dropping, because a 12-strip region holds at most 6 runs, which is also the per-region record capacity.
- R7: Records leave in ascending region order. Within a region, the highest cluster comes first and positions descend.
- R8: Call the clock edge that samples `start_i` high in the idle state edge 0. The first record is valid in the cycle after edge 7, and records follow on consecutive cycles with no gaps.
- R9: `done_o` is high for exactly one cycle, one cycle after the last record. When there are no clusters, it is high in the cycle after edge 7. It is never high together with `clu_valid_o`.
- R10: A `start_i` pulse or a change of `hits_i` while a scan is in progress has no effect on the record stream or on the done timing of that scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Capture `hits_i` and begin a scan (accepted when idle) |
| hits_i | input | 144 | Strip hit vector, bit i = strip i |
| clu_valid_o | output | 1 | A cluster record is present this cycle |
| clu_center_o | output | 8 | Absolute strip number of the cluster centre |
| clu_width_o | output | 3 | Cluster width in strips, saturated at 7 |
| done_o | output | 1 | One-cycle pulse after the final record of a scan |

## Verification
The assertions assume that `start_i` matters only in the idle state. They also assume that `hits_i` is sampled solely on the accepting edge, so nothing the environment does mid-scan may reach the mark vectors or the record slots. The stimulus respects this. It raises `start_i` for one cycle per scan, waits until the done pulse has passed before it starts the next scan, and deliberately pulses `start_i` and inverts `hits_i` in the middle of one scan to show that they are ignored. The patterns cover empty and full vectors, alternating strips that fill every region to capacity, saturating widths, runs across boundaries, and pseudo-random vectors.

// File: rtl/scf_pkg.sv
// Package: shared defaults and the sequencer state type for the strip
// cluster finder. Assumes the strip count is a whole number of regions.
package scf_pkg;
    localparam int DEF_STRIPS  = 144;
    localparam int DEF_REG_W   = 12;
    localparam int DEF_MAX_CLU = 6;
    localparam int DEF_POS_W   = 8;
    localparam int DEF_WID_W   = 3;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_PEEL = 2'd1,
        SQ_EMIT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/scf_region.sv
// Region engine: on load, it forms begin and end mark vectors for one region,
// treating strips outside the region as empty. On each peel cycle it encodes
// the topmost begin and end marks, which belong to the same run, stores a
// centre/width record, and clears both marks.
// Assumes: load_i and peel_i are never high together.
module scf_region #(
    parameter int REG_W   = 12,
    parameter int MAX_CLU = 6,
    parameter int POS_W   = 8,
    parameter int WID_W   = 3,
    parameter int BASE    = 0,
    localparam int CNT_W  = $clog2(MAX_CLU + 1),
    localparam int REC_W  = POS_W + WID_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic                     peel_i,
    input  logic [REG_W-1:0]         bits_i,
    output logic [CNT_W-1:0]         cnt_o,
    output logic [MAX_CLU*REC_W-1:0] recs_o
);
    localparam int IDX_W   = $clog2(REG_W);
    localparam int WID_MAX = (1 << WID_W) - 1;

    logic [REG_W-1:0] beg_q, end_q;
    logic [IDX_W-1:0] beg_top, end_top;
    logic [CNT_W-1:0] cnt_q;
    logic [REC_W-1:0] rec_q [MAX_CLU];
    logic [IDX_W:0]   span_sum, span_len;
    logic [POS_W-1:0] center;
    logic [WID_W-1:0] width;

    // Priority encode the most significant remaining begin and end marks.
    always_comb begin
        beg_top = '0;
        end_top = '0;
        for (int i = 0; i < REG_W; i++) begin
            if (beg_q[i]) beg_top = IDX_W'(i);
            if (end_q[i]) end_top = IDX_W'(i);
        end
    end

    // Centre is the region base plus the rounded-down midpoint; width saturates.
    always_comb begin
        span_sum = {1'b0, beg_top} + {1'b0, end_top};
        span_len = {1'b0, end_top} - {1'b0, beg_top} + 1'b1;
        center   = POS_W'(BASE) + POS_W'(span_sum >> 1);
        width    = (span_len > (IDX_W+1)'(WID_MAX)) ? WID_W'(WID_MAX) : WID_W'(span_len);
    end

    // Mark capture on load, then one run peeled per clock into the next slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beg_q <= '0;
            end_q <= '0;
            cnt_q <= '0;
            for (int k = 0; k < MAX_CLU; k++) rec_q[k] <= '0;
        end else if (load_i) begin
            beg_q <= bits_i & ~(bits_i << 1);
            end_q <= bits_i & ~(bits_i >> 1);
            cnt_q <= '0;
        end else if (peel_i && (beg_q != '0)) begin
            beg_q[beg_top] <= 1'b0;
            end_q[end_top] <= 1'b0;
            if (cnt_q < CNT_W'(MAX_CLU)) begin
                for (int k = 0; k < MAX_CLU; k++)
                    if (cnt_q == CNT_W'(k)) rec_q[k] <= {center, width};
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Flatten the record slots for the merger.
    for (genvar k = 0; k < MAX_CLU; k++) begin : g_flat
        assign recs_o[k*REC_W +: REC_W] = rec_q[k];
    end
    assign cnt_o = cnt_q;

    AST_MARK_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(beg_q) == $countones(end_q)); // R2
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_CLU)); // R6
    AST_END_ABOVE_BEGIN: assert property (@(posedge clk) disable iff (!rst_n)
        (peel_i && beg_q != '0) |-> (end_top >= beg_top)); // R4
endmodule

// File: rtl/scf_merge.sv
// Merger: it treats all region slots as one flat list ordered by region, then
// slot. Each emit cycle it sends the lowest filled, not-yet-served slot.
// Assumes: slot counts and records are stable while emit_i is high, and
// clear_i is raised together with the regions' load.
module scf_merge #(
    parameter int NUM_REG = 12,
    parameter int REG_W   = 12,
    parameter int MAX_CLU = 6,
    parameter int POS_W   = 8,
    parameter int WID_W   = 3,
    localparam int CNT_W  = $clog2(MAX_CLU + 1),
    localparam int REC_W  = POS_W + WID_W,
    localparam int SLOTS  = NUM_REG * MAX_CLU
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear_i,
    input  logic                   emit_i,
    input  logic [NUM_REG*CNT_W-1:0] cnt_i,
    input  logic [SLOTS*REC_W-1:0] recs_i,
    output logic                   valid_o,
    output logic [POS_W-1:0]       center_o,
    output logic [WID_W-1:0]       width_o,
    output logic                   empty_o
);
    localparam int SLOT_W = $clog2(SLOTS);

    logic [SLOTS-1:0]  filled, served_q, pending;
    logic [SLOT_W-1:0] pick;
    logic [REC_W-1:0]  pick_rec;

    // A slot is filled when its index is below its region's record count.
    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
        for (genvar k = 0; k < MAX_CLU; k++) begin : g_slot
            assign filled[r*MAX_CLU + k] = (cnt_i[r*CNT_W +: CNT_W] > CNT_W'(k));
        end
    end

    // Select the lowest pending slot.
    always_comb begin
        pending = filled & ~served_q;
        pick    = '0;
        for (int s = SLOTS - 1; s >= 0; s--)
            if (pending[s]) pick = SLOT_W'(s);
        pick_rec = recs_i[pick*REC_W +: REC_W];
    end
    assign empty_o = (pending == '0);

    // Register one record per emit cycle and mark its slot as served.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            served_q <= '0;
            valid_o  <= 1'b0;
            center_o <= '0;
            width_o  <= '0;
        end else begin
            valid_o <= 1'b0;
            if (emit_i && !empty_o) begin
                valid_o        <= 1'b1;
                center_o       <= pick_rec[REC_W-1:WID_W];
                width_o        <= pick_rec[WID_W-1:0];
                served_q[pick] <= 1'b1;
            end
        end
    end

    AST_SERVED_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
        (served_q & ~filled) == '0); // R6
    AST_CENTER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (center_o < POS_W'(NUM_REG * REG_W))); // R4
endmodule

// File: rtl/strip_cluster_finder.sv
// Top: it accepts a hit snapshot when idle, peels all regions in parallel for
// MAX_CLU cycles, then streams the stored records through the merger and
// pulses done after the last one.
// Assumes: STRIPS is a multiple of REG_W, and the absolute strip number fits POS_W.
module strip_cluster_finder
    import scf_pkg::*;
#(
    parameter int STRIPS  = DEF_STRIPS,
    parameter int REG_W   = DEF_REG_W,
    parameter int MAX_CLU = DEF_MAX_CLU,
    parameter int POS_W   = DEF_POS_W,
    parameter int WID_W   = DEF_WID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [STRIPS-1:0] hits_i,
    output logic              clu_valid_o,
    output logic [POS_W-1:0]  clu_center_o,
    output logic [WID_W-1:0]  clu_width_o,
    output logic              done_o
);
    localparam int NUM_REG = STRIPS / REG_W;
    localparam int CNT_W   = $clog2(MAX_CLU + 1);
    localparam int REC_W   = POS_W + WID_W;
    localparam int PC_W    = $clog2(MAX_CLU) > 0 ? $clog2(MAX_CLU) : 1;

    seq_state_e state_q;
    logic [PC_W-1:0] pcnt_q;
    logic load, peel, emit, merge_empty, done_q;
    logic [NUM_REG*CNT_W-1:0]         cnt_all;
    logic [NUM_REG*MAX_CLU*REC_W-1:0] recs_all;

    assign load = (state_q == SQ_IDLE) && start_i;
    assign peel = (state_q == SQ_PEEL);
    assign emit = (state_q == SQ_EMIT);

    // Sequencer: idle -> fixed-length peel -> emit until the merger is empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            pcnt_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SQ_IDLE: if (start_i) begin
                    state_q <= SQ_PEEL;
                    pcnt_q  <= '0;
                end
                SQ_PEEL: begin
                    pcnt_q <= pcnt_q + 1'b1;
                    if (pcnt_q == PC_W'(MAX_CLU - 1)) state_q <= SQ_EMIT;
                end
                SQ_EMIT: if (merge_empty) begin
                    done_q  <= 1'b1;
                    state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // One engine per region of strips.
    for (genvar g = 0; g < NUM_REG; g++) begin : g_region
        scf_region #(
            .REG_W(REG_W), .MAX_CLU(MAX_CLU), .POS_W(POS_W),
            .WID_W(WID_W), .BASE(g * REG_W)
        ) region_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load),
            .peel_i (peel),
            .bits_i (hits_i[g*REG_W +: REG_W]),
            .cnt_o  (cnt_all[g*CNT_W +: CNT_W]),
            .recs_o (recs_all[g*MAX_CLU*REC_W +: MAX_CLU*REC_W])
        );
    end

    scf_merge #(
        .NUM_REG(NUM_REG), .REG_W(REG_W), .MAX_CLU(MAX_CLU),
        .POS_W(POS_W), .WID_W(WID_W)
    ) merge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (load),
        .emit_i   (emit),
        .cnt_i    (cnt_all),
        .recs_i   (recs_all),
        .valid_o  (clu_valid_o),
        .center_o (clu_center_o),
        .width_o  (clu_width_o),
        .empty_o  (merge_empty)
    );

    assign done_o = done_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && clu_valid_o)); // R9
    AST_WIDTH_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clu_valid_o |-> (clu_width_o != '0)); // R5
    AST_PEEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (peel && start_i) |=> (state_q != SQ_IDLE)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_IDLE && !$past(emit)) |-> !clu_valid_o); // R8
endmodule

// File: tb/strip_cluster_finder_tb_top.sv
// Bench: a behavioural model builds the expected record list and timing for
// each snapshot, and the outputs are compared on every clock.
module strip_cluster_finder_tb_top;
    localparam int STRIPS = 144;
    localparam int LAT    = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [STRIPS-1:0] hits_i = '0;
    logic              clu_valid_o;
    logic [7:0]        clu_center_o;
    logic [2:0]        clu_width_o;
    logic              done_o;

    int checks = 0;
    int failures = 0;
    int exp_c[$];
    int exp_w[$];

    always #2 clk = ~clk;

    strip_cluster_finder dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .hits_i(hits_i),
        .clu_valid_o(clu_valid_o), .clu_center_o(clu_center_o),
        .clu_width_o(clu_width_o), .done_o(done_o)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // Reference: runs per region, top-down, region-local edges closed.
    function automatic void build_model(input logic [STRIPS-1:0] h);
        exp_c.delete();
        exp_w.delete();
        for (int r = 0; r < STRIPS / 12; r++) begin
            int i = 11;
            while (i >= 0) begin
                if (h[12*r + i]) begin
                    int hi = i;
                    int lo;
                    while (i >= 0 && h[12*r + i]) i--;
                    lo = i + 1;
                    exp_c.push_back(12*r + (lo + hi) / 2);
                    exp_w.push_back((hi - lo + 1) > 7 ? 7 : (hi - lo + 1));
                end else begin
                    i--;
                end
            end
        end
    endfunction

    // One scan, compared every cycle; optional mid-scan disturbance (R10).
    task automatic run_scan(input logic [STRIPS-1:0] h, input string tname, input bit disturb);
        int n;
        build_model(h);
        n = exp_c.size();
        @(negedge clk);
        hits_i  = h;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c <= LAT + n + 1; c++) begin
            bit ev = (c >= LAT) && (c < LAT + n);
            check({tname, " R8 valid"}, int'(clu_valid_o), int'(ev));
            check({tname, " R9 done"}, int'(done_o), int'(c == LAT + n));
            if (ev && clu_valid_o) begin
                check({tname, " R4 R7 center"}, int'(clu_center_o), exp_c[c - LAT]);
                check({tname, " R5 width"}, int'(clu_width_o), exp_w[c - LAT]);
            end
            if (disturb && c == 3) begin
                hits_i  = ~h;
                start_i = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
        end
    endtask

    initial begin
        logic [STRIPS-1:0] v;
        repeat (3) @(negedge clk);
        check("R1 reset valid", int'(clu_valid_o), 0);
        check("R1 reset done", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset valid", int'(clu_valid_o), 0);
        check("R1 post-reset done", int'(done_o), 0);

        run_scan('0, "empty R9", 1'b0);
        v = '0; v[0] = 1'b1; v[5] = 1'b1;
        run_scan(v, "singles R2 R7", 1'b0);
        v = '0; v[17:14] = '1;
        run_scan(v, "run4 R4", 1'b0);
        v = '0; v[13:10] = '1;
        run_scan(v, "boundary R3", 1'b0);
        v = '0; v[35:24] = '1;
        run_scan(v, "full region saturate R5", 1'b0);
        v = '0;
        for (int i = 0; i < STRIPS; i += 2) v[i] = 1'b1;
        run_scan(v, "even strips R6", 1'b0);
        run_scan(v << 1, "odd strips R6", 1'b0);
        run_scan('1, "all ones R3 R5", 1'b0);
        v = '0; v[40] = 1'b1; v[100:90] = '1; v[143] = 1'b1;
        run_scan(v, "busy ignored R10", 1'b1);
        for (int t = 0; t < 6; t++) begin
            for (int w = 0; w < STRIPS; w += 32) v[w +: 16] = 16'($urandom);
            for (int w = 16; w < STRIPS; w += 32) v[w +: 16] = 16'($urandom);
            run_scan(v, "random R2 R7", 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule